// File: doc/BRIEF.md
# Flash In-System Programming Command Sequencer

The sequencer sits between a CPU register port and an embedded flash array. Software loads an operation mode, a two-byte page address and a control byte. The control byte holds an enable bit, a boot-select bit, a software-reset trigger and a three-bit busy-time select. A flash operation is launched only when the enable bit is set and a two-byte unlock key is written to the command port. The block then sends a one-cycle start strobe, with the operation and address, to the flash cell model. It also raises a CPU hold for a busy time taken from a table indexed by operation and select code.

A read of the command port returns one byte of a two-byte device identifier. The byte is chosen by bit 0 of the low address byte. Writing 1 to the software-reset bit produces a one-cycle system reset pulse and clears the bit again. That reset clears every register except the enable and boot-select bits, which only the power-on reset `rst_ni` clears. One machine cycle equals one clock cycle.

Top module: `flash_isp_seq`

## Requirements
- R1: After power-on reset every register reads 0, `cpu_hold_o`, `flash_start_o` and `sw_rst_o` are 0, and a read of the command port (address 4) returns F1h.
- R2: Register addresses are 0 mode, 1 address high, 2 address low, 3 control, 4 command, 5 status. Control bit 7 is enable, bit 6 boot select, bit 5 software reset, and bits [2:0] are the busy select. Command writes of 46h and then B9h, with no other command write between them and enable at 1, start an operation. Writes to other registers between the two keys do not break the sequence.
- R3: A command byte other than the expected next key returns the detector to idle, so 46h, 46h, B9h starts nothing. A complete key sequence written while enable is 0 starts nothing.
- R4: Mode bits [2:0] select the operation: 001 read, 010 program, 011 page erase. On the clock edge that accepts B9h, `flash_start_o` pulses high for one cycle. With it, `flash_op_o` (1 read, 2 program, 3 erase) and `flash_addr_o` = {address high, address low} are presented.
- R5: `cpu_hold_o` rises on the same edge as the start strobe and stays high for exactly N cycles. For select 0..3, N is 43769/21885/10942/5471 for erase, 240/120/60/30 for program and 43/22/11/6 for read.
- R6: Mode codes other than 001, 010 and 011, and select codes 4 to 7, produce no strobe and no hold.
- R7: A command-port read returns F1h when address-low bit 0 is 0 and 04h when it is 1.
- R8: Status bit 0 reads 1 while an operation is busy. All register writes, including command writes, are ignored while busy.
- R9: Writing control with bit 5 set makes control bit 5 read 1 for one cycle. `sw_rst_o` is high for exactly one cycle, after which bit 5 reads 0.
- R10: The software reset clears mode, address, busy select and the unlock detector, but keeps enable and boot select (`boot_sel_o`). Only `rst_ni` clears those two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for write and read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| cpu_hold_o | output | 1 | CPU stall during flash busy time |
| sw_rst_o | output | 1 | One-cycle software system reset pulse |
| boot_sel_o | output | 1 | Boot select, 1 selects ISP memory |
| flash_start_o | output | 1 | One-cycle operation start strobe |
| flash_op_o | output | 2 | Operation code with the strobe |
| flash_addr_o | output | 16 | Page address with the strobe |

## Verification
The hardest state to reach is a register write that arrives while the busy timer is running. It only exists after a full unlock and inside a window whose length depends on both mode and select. The bench starts a long erase and, while the hold is still high, writes new mode and control values and a fresh key pair. It then reads everything back after the hold drops. Random operations with random select codes and addresses cover the busy table. Directed sequences interleave a software reset between the two keys, to show that the detector is cleared while the enable bit is kept.

// File: rtl/flash_isp_pkg.sv
package flash_isp_pkg;
  localparam int DW     = 8;
  localparam int AW     = 3;
  localparam int SEL_W  = 3;

  localparam logic [AW-1:0] A_MODE = 3'd0;
  localparam logic [AW-1:0] A_AHI  = 3'd1;
  localparam logic [AW-1:0] A_ALO  = 3'd2;
  localparam logic [AW-1:0] A_CTRL = 3'd3;
  localparam logic [AW-1:0] A_CMD  = 3'd4;
  localparam logic [AW-1:0] A_STAT = 3'd5;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_PROG  = 2'd2,
    OP_ERASE = 2'd3
  } isp_op_e;

  function automatic isp_op_e decode_mode(logic [2:0] m);
    case (m)
      3'b001:  return OP_READ;
      3'b010:  return OP_PROG;
      3'b011:  return OP_ERASE;
      default: return OP_NONE;
    endcase
  endfunction

  // busy time in machine cycles; 0 means the select code is not defined
  function automatic int unsigned busy_mc(isp_op_e op, logic [SEL_W-1:0] sel);
    int unsigned n;
    n = 0;
    if (sel < 3'd4) begin
      case (op)
        OP_ERASE: case (sel[1:0])
                    2'd0: n = 43769; 2'd1: n = 21885; 2'd2: n = 10942; default: n = 5471;
                  endcase
        OP_PROG:  n = 240 >> sel[1:0];
        OP_READ:  case (sel[1:0])
                    2'd0: n = 43; 2'd1: n = 22; 2'd2: n = 11; default: n = 6;
                  endcase
        default:  n = 0;
      endcase
    end
    return n;
  endfunction
endpackage

// File: rtl/isp_regs.sv
module isp_regs
  import flash_isp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             busy_i,
  output logic [DW-1:0]    mode_o,
  output logic [DW-1:0]    adr_hi_o,
  output logic [DW-1:0]    adr_lo_o,
  output logic             en_o,
  output logic             boot_o,
  output logic             swrst_o,
  output logic [SEL_W-1:0] sel_o
);
  logic [DW-1:0]    mode_q, ahi_q, alo_q;
  logic [SEL_W-1:0] sel_q;
  logic             en_q, boot_q, swrst_q;
  logic             wr_ok;

  assign wr_ok = wr_en_i && !busy_i && !swrst_q;

  // soft-reset domain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      ahi_q   <= '0;
      alo_q   <= '0;
      sel_q   <= '0;
      swrst_q <= 1'b0;
    end else if (swrst_q) begin
      mode_q  <= '0;
      ahi_q   <= '0;
      alo_q   <= '0;
      sel_q   <= '0;
      swrst_q <= 1'b0;
    end else if (wr_ok) begin
      case (addr_i)
        A_MODE: mode_q <= wdata_i;
        A_AHI:  ahi_q  <= wdata_i;
        A_ALO:  alo_q  <= wdata_i;
        A_CTRL: begin
          sel_q   <= wdata_i[SEL_W-1:0];
          swrst_q <= wdata_i[5];
        end
        default: ;
      endcase
    end
  end

  // power-on-only domain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      boot_q <= 1'b0;
    end else if (wr_ok && addr_i == A_CTRL) begin
      en_q   <= wdata_i[7];
      boot_q <= wdata_i[6];
    end
  end

  assign mode_o   = mode_q;
  assign adr_hi_o = ahi_q;
  assign adr_lo_o = alo_q;
  assign en_o     = en_q;
  assign boot_o   = boot_q;
  assign swrst_o  = swrst_q;
  assign sel_o    = sel_q;

  AST_SWRST_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_q |=> !swrst_q); // R9
  AST_SWRST_KEEPS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_q |=> (en_q == $past(en_q)) && (boot_q == $past(boot_q))); // R10
  AST_SWRST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_q |=> mode_q == '0 && sel_q == '0 && ahi_q == '0 && alo_q == '0); // R10
  AST_NO_WRITE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !swrst_q |=> $stable(mode_q) && $stable(sel_q) && $stable(en_q)); // R8
endmodule

// File: rtl/isp_unlock_det.sv
module isp_unlock_det #(
  parameter int          DW   = 8,
  parameter logic [DW-1:0] KEY0 = 8'h46,
  parameter logic [DW-1:0] KEY1 = 8'hB9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          cmd_wr_i,
  input  logic [DW-1:0] cmd_i,
  output logic          hit_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       armed_q <= 1'b0;
    else if (clr_i)    armed_q <= 1'b0;
    else if (cmd_wr_i) armed_q <= !armed_q && (cmd_i == KEY0);
  end

  assign hit_o = armed_q && cmd_wr_i && (cmd_i == KEY1) && !clr_i;

  AST_ARM_FROM_KEY0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(cmd_wr_i) && $past(cmd_i) == KEY0); // R2
  AST_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> !armed_q); // R3
endmodule

// File: rtl/isp_busy_timer.sv
module isp_busy_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cycles_i,
  output logic             busy_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= cycles_i - 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;

  AST_CNT_DECR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && cnt_q != '0 && !start_i |=> busy_q && cnt_q == $past(cnt_q) - 1'b1); // R5
  AST_BUSY_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && cnt_q == '0 && !start_i |=> !busy_q); // R5
  AST_START_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> cycles_i != '0 && !busy_q); // R6
endmodule

// File: rtl/flash_isp_seq.sv
module flash_isp_seq
  import flash_isp_pkg::*;
#(
  parameter int          CNT_W  = 16,
  parameter logic [7:0]  KEY0   = 8'h46,
  parameter logic [7:0]  KEY1   = 8'hB9,
  parameter logic [7:0]  ID_HI  = 8'hF1,
  parameter logic [7:0]  ID_LO  = 8'h04
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [2:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        cpu_hold_o,
  output logic        sw_rst_o,
  output logic        boot_sel_o,
  output logic        flash_start_o,
  output logic [1:0]  flash_op_o,
  output logic [15:0] flash_addr_o
);
  localparam int FA_W = 2 * DW;

  logic [DW-1:0]    mode, ahi, alo;
  logic [SEL_W-1:0] sel;
  logic             en, boot, swrst, busy, hit, trig, cmd_wr;
  isp_op_e          op;
  logic [CNT_W-1:0] cycles;
  logic             start_q;
  isp_op_e          op_q;
  logic [FA_W-1:0]  fa_q;

  isp_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .busy_i  (busy),
    .mode_o  (mode),
    .adr_hi_o(ahi),
    .adr_lo_o(alo),
    .en_o    (en),
    .boot_o  (boot),
    .swrst_o (swrst),
    .sel_o   (sel)
  );

  assign cmd_wr = wr_en_i && addr_i == A_CMD && !busy;

  isp_unlock_det #(.DW(DW), .KEY0(KEY0), .KEY1(KEY1)) u_det (
    .clk_i, .rst_ni,
    .clr_i   (swrst),
    .cmd_wr_i(cmd_wr),
    .cmd_i   (wdata_i),
    .hit_o   (hit)
  );

  assign op     = decode_mode(mode[2:0]);
  assign cycles = CNT_W'(busy_mc(op, sel));
  assign trig   = hit && en && cycles != '0;

  isp_busy_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni,
    .start_i (trig),
    .cycles_i(cycles),
    .busy_o  (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      op_q    <= OP_NONE;
      fa_q    <= '0;
    end else begin
      start_q <= trig;
      if (trig) begin
        op_q <= op;
        fa_q <= {ahi, alo};
      end
    end
  end

  always_comb begin
    case (addr_i)
      A_MODE:  rdata_o = mode;
      A_AHI:   rdata_o = ahi;
      A_ALO:   rdata_o = alo;
      A_CTRL:  rdata_o = {en, boot, swrst, 2'b00, sel};
      A_CMD:   rdata_o = alo[0] ? ID_LO : ID_HI;
      A_STAT:  rdata_o = {7'd0, busy};
      default: rdata_o = '0;
    endcase
  end

  assign cpu_hold_o    = busy;
  assign sw_rst_o      = swrst;
  assign boot_sel_o    = boot;
  assign flash_start_o = start_q;
  assign flash_op_o    = op_q;
  assign flash_addr_o  = fa_q;

  AST_START_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_start_o |-> $past(en)); // R3
  AST_START_WITH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_start_o |-> cpu_hold_o && flash_op_o != OP_NONE); // R4
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_start_o |=> !flash_start_o); // R4
endmodule

// File: tb/test_flash_isp_seq.sv
`timescale 1ns/1ps
module test_flash_isp_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        hold, swr, boot, fstart;
  logic [1:0]  fop;
  logic [15:0] faddr;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flash_isp_seq i_flash_isp_seq (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .cpu_hold_o(hold), .sw_rst_o(swr), .boot_sel_o(boot),
    .flash_start_o(fstart), .flash_op_o(fop), .flash_addr_o(faddr)
  );

  function automatic int exp_cycles(int op, int sel);
    int e[4] = '{43769, 21885, 10942, 5471};
    int p[4] = '{240, 120, 60, 30};
    int r[4] = '{43, 22, 11, 6};
    if (sel > 3) return 0;
    case (op)
      1: return r[sel];
      2: return p[sel];
      3: return e[sel];
      default: return 0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  // unlock, then measure strobe and hold length
  task automatic launch(int op, int sel, logic [15:0] pa, string req);
    int n, exp_n;
    bit s2;
    exp_n = exp_cycles(op, sel);
    wr(3'd4, 8'h46);
    wr(3'd4, 8'hB9);
    if (exp_n == 0) begin
      chk(!fstart && !hold, "R6", {fstart, hold}, 0);
      repeat (3) begin @(posedge clk); #1; end
      chk(!hold, "R6", hold, 0);
      return;
    end
    chk(fstart && fop == 2'(op) && faddr == pa, "R4", {fstart, fop, faddr}, {1'b1, 2'(op), pa});
    n = 0; s2 = 0;
    while (hold && n < 50000) begin
      n++;
      @(posedge clk); #1;
      if (n == 1) s2 = fstart;
    end
    chk(!s2, "R4", s2, 0);
    chk(n == exp_n, req, n, exp_n);
  endtask

  task automatic setup(logic [7:0] mode, int sel, logic [15:0] pa, bit en);
    wr(3'd0, mode);
    wr(3'd1, pa[15:8]);
    wr(3'd2, pa[7:0]);
    wr(3'd3, {en, 1'b0, 1'b0, 2'b00, 3'(sel)});
  endtask

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int op, sel;
    logic [15:0] pa;
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk(d == (a == 4 ? 8'hF1 : 8'h00), "R1", d, a == 4 ? 8'hF1 : 8'h00);
    end
    chk(!hold && !fstart && !swr && !boot, "R1", {hold, fstart, swr, boot}, 0);

    // R7
    wr(3'd2, 8'h01); rd(3'd4, d); chk(d == 8'h04, "R7", d, 8'h04);
    wr(3'd2, 8'hFE); rd(3'd4, d); chk(d == 8'hF1, "R7", d, 8'hF1);

    // R5 random program/read
    for (int i = 0; i < 20; i++) begin
      op  = 1 + ($urandom % 2);
      sel = $urandom % 4;
      pa  = 16'($urandom);
      setup(8'(op), sel, pa, 1'b1);
      launch(op, sel, pa, "R5");
    end
    // R5 erase
    setup(8'h03, 3, 16'h1200, 1'b1); launch(3, 3, 16'h1200, "R5");
    setup(8'hF3, 0, 16'hABCD, 1'b1); launch(3, 0, 16'hABCD, "R5");

    // R2 other reg write between keys
    setup(8'h01, 2, 16'h0042, 1'b1);
    wr(3'd4, 8'h46);
    wr(3'd1, 8'h77);
    wr(3'd4, 8'hB9);
    chk(fstart && faddr == 16'h7742, "R2", faddr, 16'h7742);
    while (hold) begin @(posedge clk); #1; end

    // R3 broken keys and disabled
    setup(8'h02, 1, 16'h0010, 1'b1);
    wr(3'd4, 8'h46); wr(3'd4, 8'h46); wr(3'd4, 8'hB9);
    chk(!fstart && !hold, "R3", {fstart, hold}, 0);
    wr(3'd4, 8'h46); wr(3'd4, 8'h00); wr(3'd4, 8'hB9);
    chk(!fstart && !hold, "R3", {fstart, hold}, 0);
    setup(8'h02, 1, 16'h0010, 1'b0);
    wr(3'd4, 8'h46); wr(3'd4, 8'hB9);
    chk(!fstart && !hold, "R3", {fstart, hold}, 0);

    // R6 undefined modes and select codes
    for (int i = 0; i < 6; i++) begin
      op  = (i < 3) ? 1 + ($urandom % 3) : (($urandom % 2) ? 0 : 4 + ($urandom % 4));
      sel = (i < 3) ? 4 + ($urandom % 4) : $urandom % 4;
      setup(8'(op), sel, 16'h0100, 1'b1);
      launch(op > 3 ? 0 : op, sel, 16'h0100, "R6");
    end

    // R8 writes ignored while busy
    setup(8'h03, 3, 16'h0200, 1'b1);
    wr(3'd4, 8'h46); wr(3'd4, 8'hB9);
    rd(3'd5, d); chk(d == 8'h01, "R8", d, 1);
    wr(3'd0, 8'h55);
    wr(3'd3, 8'h20);
    wr(3'd4, 8'h46); wr(3'd4, 8'hB9);
    chk(hold && !fstart, "R8", {hold, fstart}, 2);
    while (hold) begin @(posedge clk); #1; end
    rd(3'd5, d); chk(d == 8'h00, "R8", d, 0);
    rd(3'd0, d); chk(d == 8'h03, "R8", d, 8'h03);
    rd(3'd3, d); chk(d == 8'h83, "R8", d, 8'h83);
    chk(!swr, "R8", swr, 0);

    // R9 / R10 software reset
    wr(3'd0, 8'h02); wr(3'd1, 8'h12); wr(3'd2, 8'h34);
    wr(3'd3, 8'hC1);
    chk(boot, "R10", boot, 1);
    wr(3'd4, 8'h46);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = 3'd3; wdata = 8'hE1;
    @(posedge clk); #1;
    wr_en = 1'b0;
    chk(swr, "R9", swr, 1);
    rd(3'd3, d); chk(d == 8'hE1, "R9", d, 8'hE1);
    @(posedge clk); #1;
    chk(!swr, "R9", swr, 0);
    rd(3'd3, d); chk(d == 8'hC0, "R10", d, 8'hC0);
    rd(3'd0, d); chk(d == 8'h00, "R10", d, 0);
    rd(3'd1, d); chk(d == 8'h00, "R10", d, 0);
    chk(boot, "R10", boot, 1);
    wr(3'd4, 8'hB9);
    chk(!fstart && !hold, "R10", {fstart, hold}, 0);
    // power-on clears enable and boot
    @(posedge clk); #1 rst_n = 1'b0;
    #10 rst_n = 1'b1;
    rd(3'd3, d); chk(d == 8'h00 && !boot, "R10", d, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule